// File: doc/BRIEF.md
# Lane-Granular Circuit-Switched Crossbar

This block is the datapath of a statically scheduled circuit-switched router with five ports: north, east, south, west and local. Each port is 64 bits wide and is divided into four independent 16-bit lanes. That gives 20 input lanes and 20 output lanes. The lanes carry no routing or control bits. Paths are fixed entirely by a small table that holds one entry per output lane. Each entry names the input lane that feeds that output lane, and it carries a valid bit.

An external agent loads the table one entry at a time through a write port. It then streams data through the crossbar, and the data arrives on the registered outputs one cycle later. Each output lane can choose only among the sixteen lanes of the other four ports, so traffic can never turn back to the port it came from. One input lane may feed any number of output lanes.

Global lane number g = 4*port + lane. The port numbers are north 0, east 1, south 2, west 3 and local 4. Lane g occupies bits [16g+15:16g] of the data buses and bit g of the valid buses.

Top module: `lane_xbar`

## Requirements
- R1: A table entry is 5 bits: bit 4 is valid and bits 3:0 are an index i. For output lane g of port p, the index selects source port q = i/4 if i/4 < p, or i/4+1 otherwise. It selects lane i%4 of that port, which is global lane 4q + i%4. For example, index 0 on port 0 picks global lane 4, and index 15 on port 4 picks global lane 15.
- R2: An output lane is never driven from an input lane of its own port.
- R3: An output lane whose entry is invalid drives all-zero data, and its valid flag is low.
- R4: Input data sampled at a rising clock edge appears on the selected output lane right after that edge, and not earlier. This is one register of latency.
- R5: The valid flag of the selected input lane is registered together with its data and appears as the valid flag of the output lane.
- R6: An active-low asynchronous reset clears every table valid bit and zeroes all outputs. After reset, no output lane carries data until an entry has been written for it.
- R7: A write (cfg_we high, cfg_addr = output lane, cfg_entry = entry) is taken at a rising edge. Data sampled at that same edge still uses the old entry. Data sampled at the following edge uses the new entry. Entries that are not written keep their value.
- R8: A write to an address from 20 to 31 changes no entry.
- R9: Several output lanes may select the same input lane. Each of them carries that lane's data in the same cycle.
- R10: The four lanes of one output port switch independently, so they may take data from four different ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 320 | Input lane data, lane g at bits [16g+15:16g] |
| in_vld | input | 20 | Input lane valid flags |
| cfg_we | input | 1 | Table write enable |
| cfg_addr | input | 5 | Output lane number written |
| cfg_entry | input | 5 | Entry written: bit 4 valid, bits 3:0 index |
| out_data | output | 320 | Registered output lane data |
| out_vld | output | 20 | Registered output lane valid flags |

## Verification
The hardest situation to reach from the ports is the edge at which a table entry changes while data is flowing. At that single edge the old entry must still route the data, and the new entry must route the data at the next edge. The stimulus therefore changes entries in the middle of streams of fresh random data on every lane. The scoreboard model applies each write only after it has predicted the outputs for that same cycle. Further cases cover entries at the extremes of the index range on the first and last ports, many output lanes fed from one input lane, and writes to addresses beyond the last lane. Traffic is also offered only on one port, which must never come back out of that port.

// File: rtl/lane_xbar.sv
module lane_xbar #(
  parameter int PORTS = 5,
  parameter int LANES = 4,
  parameter int LW    = 16,
  localparam int NL    = PORTS * LANES,
  localparam int OTHER = (PORTS - 1) * LANES,
  localparam int IW    = $clog2(OTHER),
  localparam int AW    = $clog2(NL)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NL*LW-1:0]   in_data,
  input  logic [NL-1:0]      in_vld,
  input  logic               cfg_we,
  input  logic [AW-1:0]      cfg_addr,
  input  logic [IW:0]        cfg_entry,
  output logic [NL*LW-1:0]   out_data,
  output logic [NL-1:0]      out_vld
);

  logic [IW-1:0] tbl_idx [NL];
  logic [NL-1:0] tbl_v;
  logic [LW-1:0] nxt_d [NL];
  logic [NL-1:0] nxt_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_v <= '0;
      for (int g = 0; g < NL; g++) tbl_idx[g] <= '0;
    end else if (cfg_we && cfg_addr < AW'(NL)) begin
      tbl_v[cfg_addr]   <= cfg_entry[IW];
      tbl_idx[cfg_addr] <= cfg_entry[IW-1:0];
    end
  end

  for (genvar g = 0; g < NL; g++) begin : g_out
    localparam int P = g / LANES;
    logic [LW-1:0]    cand_d [OTHER];
    logic [OTHER-1:0] cand_v;
    for (genvar k = 0; k < OTHER; k++) begin : g_cand
      localparam int Q0 = k / LANES;
      localparam int Q  = (Q0 >= P) ? Q0 + 1 : Q0;
      localparam int S  = Q * LANES + (k % LANES);
      assign cand_d[k] = in_data[S*LW +: LW];
      assign cand_v[k] = in_vld[S];
    end
    assign nxt_d[g] = tbl_v[g] ? cand_d[tbl_idx[g]] : '0;
    assign nxt_v[g] = tbl_v[g] & cand_v[tbl_idx[g]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
      out_vld  <= '0;
    end else begin
      for (int g = 0; g < NL; g++) out_data[g*LW +: LW] <= nxt_d[g];
      out_vld <= nxt_v;
    end
  end

endmodule

// File: rtl/lane_xbar_chk.sv
module lane_xbar_chk #(
  parameter int PORTS = 5,
  parameter int LANES = 4,
  parameter int LW    = 16,
  localparam int NL   = PORTS * LANES,
  localparam int AW   = $clog2(NL)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NL-1:0]    in_vld,
  input logic             cfg_we,
  input logic [AW-1:0]    cfg_addr,
  input logic [NL*LW-1:0] out_data,
  input logic [NL-1:0]    out_vld,
  input logic [NL-1:0]    tbl_v
);

  for (genvar g = 0; g < NL; g++) begin : g_lane
    localparam int P = g / LANES;
    localparam logic [NL-1:0] OWN = {{(NL-LANES){1'b0}}, {LANES{1'b1}}} << (P * LANES);

    assert_invalid_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !tbl_v[g] |=> (out_vld[g] == 1'b0 && out_data[g*LW +: LW] == '0));

    assert_no_uturn_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld[g] |-> $past(|(in_vld & ~OWN)));

    assert_vld_needs_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld[g] |-> $past(tbl_v[g]));
  end

  assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(tbl_v));

  assert_bad_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr >= AW'(NL)) |=> $stable(tbl_v));

  assert_reset_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (out_vld == '0 && tbl_v == '0 && out_data == '0));

endmodule

bind lane_xbar lane_xbar_chk #(.PORTS(PORTS), .LANES(LANES), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .out_data(out_data), .out_vld(out_vld), .tbl_v(tbl_v)
);

// File: tb/tb_lane_xbar.sv
`timescale 1ns/1ps
module tb_lane_xbar;
  localparam int NL = 20;
  localparam int LW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NL*LW-1:0] in_data = '0;
  logic [NL-1:0] in_vld = '0;
  logic cfg_we = 1'b0;
  logic [4:0] cfg_addr = '0;
  logic [4:0] cfg_entry = '0;
  logic [NL*LW-1:0] out_data;
  logic [NL-1:0] out_vld;

  int vectors = 0;
  int errors = 0;
  logic [4:0] mtbl [NL];
  logic [NL*LW-1:0] q_d [$];
  logic [NL-1:0] q_v [$];
  string q_tag [$];

  always #10 clk = ~clk;

  lane_xbar dut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_vld(in_vld),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_entry(cfg_entry),
    .out_data(out_data), .out_vld(out_vld)
  );

  function automatic logic [NL*LW-1:0] rnd_data();
    logic [NL*LW-1:0] d;
    for (int i = 0; i < NL*LW/32; i++) d[i*32 +: 32] = $urandom;
    return d;
  endfunction

  task automatic drive(input logic [NL*LW-1:0] d, input logic [NL-1:0] v,
                       input logic we, input logic [4:0] a, input logic [4:0] e,
                       input string tag);
    logic [NL*LW-1:0] ed;
    logic [NL-1:0] ev;
    @(negedge clk);
    in_data = d; in_vld = v; cfg_we = we; cfg_addr = a; cfg_entry = e;
    ed = '0; ev = '0;
    for (int g = 0; g < NL; g++) begin
      int p, i, q, s;
      p = g / 4;
      if (mtbl[g][4]) begin
        i = int'(mtbl[g][3:0]);
        q = i / 4;
        if (q >= p) q++;
        s = q * 4 + i % 4;
        ed[g*LW +: LW] = d[s*LW +: LW];
        ev[g] = v[s];
      end
    end
    q_d.push_back(ed); q_v.push_back(ev); q_tag.push_back(tag);
    if (we && a < 5'd20) mtbl[a] = e;
  endtask

  task automatic data_cycle(input logic [NL-1:0] v, input string tag);
    drive(rnd_data(), v, 1'b0, 5'd0, 5'd0, tag);
  endtask

  task automatic write_cfg(input logic [4:0] a, input logic [4:0] e, input string tag);
    drive(rnd_data(), NL'($urandom), 1'b1, a, e, tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q_d.size() > 0) begin
        logic [NL*LW-1:0] ed;
        logic [NL-1:0] ev;
        string tag;
        ed = q_d.pop_front(); ev = q_v.pop_front(); tag = q_tag.pop_front();
        vectors++;
        if (out_data !== ed || out_vld !== ev) begin
          errors++;
          $display("FAIL %s: out_vld=%h out_data=%h expected out_vld=%h out_data=%h",
                   tag, out_vld, out_data, ev, ed);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL R4: watchdog expired, actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int g = 0; g < NL; g++) mtbl[g] = '0;
    in_data = rnd_data(); in_vld = '1;
    repeat (3) @(negedge clk);
    vectors++;
    if (out_vld !== '0 || out_data !== '0) begin
      errors++;
      $display("FAIL R6: reset out_vld=%h expected 0", out_vld);
    end
    rst_n = 1'b1;

    // R6: no entries after reset, so nothing passes
    for (int n = 0; n < 4; n++) data_cycle('1, "R6");

    // R1: load every output lane with a spread of indices
    for (int g = 0; g < NL; g++) write_cfg(5'(g), {1'b1, 4'((g * 5 + 3) % 16)}, "R1");
    // R4 R5: random streams with random valid flags
    for (int n = 0; n < 30; n++) data_cycle(NL'($urandom), "R5");
    for (int n = 0; n < 4; n++) data_cycle('1, "R4");

    // R1: index extremes on first and last port
    write_cfg(5'd0, 5'b1_0000, "R1");
    write_cfg(5'd19, 5'b1_1111, "R1");
    for (int n = 0; n < 4; n++) data_cycle('1, "R1");

    // R7: change an entry while data streams
    for (int n = 0; n < 6; n++) begin
      write_cfg(5'd0, {1'b1, 4'(n * 3)}, "R7");
      data_cycle('1, "R7");
    end

    // R3: invalidate entries
    write_cfg(5'd6, 5'b0_1111, "R3");
    write_cfg(5'd13, 5'b0_0010, "R3");
    for (int n = 0; n < 4; n++) data_cycle('1, "R3");

    // R9: lanes 8, 12 and 16 all take global lane 1
    write_cfg(5'd8, 5'b1_0001, "R9");
    write_cfg(5'd12, 5'b1_0001, "R9");
    write_cfg(5'd16, 5'b1_0001, "R9");
    for (int n = 0; n < 4; n++) data_cycle('1, "R9");

    // R10: port 1 lanes from four different ports
    write_cfg(5'd4, 5'b1_0000, "R10");
    write_cfg(5'd5, 5'b1_0101, "R10");
    write_cfg(5'd6, 5'b1_1010, "R10");
    write_cfg(5'd7, 5'b1_1111, "R10");
    for (int n = 0; n < 4; n++) data_cycle('1, "R10");

    // R8: out-of-range writes change nothing
    for (int a = 20; a < 32; a++) write_cfg(5'(a), 5'b0_0000, "R8");
    for (int n = 0; n < 3; n++) data_cycle('1, "R8");

    // R2: traffic only on each single port
    for (int p = 0; p < 5; p++)
      for (int n = 0; n < 3; n++) data_cycle(NL'(4'hF) << (p * 4), "R2");

    drive(rnd_data(), '0, 1'b0, 5'd0, 5'd0, "R5");
    repeat (2) @(posedge clk);
    #6;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule